// File: doc/BRIEF.md
# Stack and Subroutine Machine-Cycle Sequencer

This block produces the machine-cycle sequence for the stack-related instructions of a small 8-bit processor. These are push, pop, unconditional and conditional call, unconditional and conditional return, restart, and exchange of a register pair with the top of the stack. The decoder presents an instruction class, a condition flag and a one-clock start strobe. The block then steps through the machine cycles of that instruction. For each cycle it shows the cycle kind and its length in T-states, and it marks the first T-state of each cycle. It also emits the strobes that adjust the stack pointer.

Cycle lengths vary from one instruction to another. A fetch lasts 4 or 5 T-states. The high operand read lasts 4 T-states only on a call that is taken. The exchange uses 4-T and 5-T stack cycles. When the condition is false, the conditional cycles are dropped. Address generation, the data path and the bus pins belong to other blocks. Every pin here is a plain control or status signal and has no handshake. A start that arrives while an instruction is running is discarded, so the decoder has to wait for `done` before it issues the next instruction.

Top module: `stk_seq_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. In idle, `cyc_type`=0, `cyc_len`=0, and `cyc_start`, `sp_inc`, `sp_dec` and `done` are all 0.
- R2: Class codes on `op_class` are 0 push, 1 pop, 2 call, 3 conditional call, 4 return, 5 conditional return, 6 restart and 7 exchange-with-stack-top. Cycle kinds on `cyc_type` are 1 fetch, 2 operand low, 3 operand high, 4 stack read low, 5 stack read high, 6 stack write high and 7 stack write low. `cyc_type` and `cyc_len` hold steady for a whole machine cycle, which lasts exactly `cyc_len` clocks. `cyc_start` is high on the first clock of each machine cycle.
- R3: Push runs fetch(5), stack write high(3), stack write low(3). `sp_dec` pulses on the first clock of each write.
- R4: Pop runs fetch(4), stack read low(3), stack read high(3). `sp_inc` pulses on the last clock of each read.
- R5: Unconditional return runs the same cycles and increments as pop.
- R6: Conditional return runs fetch(5). Only when the condition is true does it continue with stack read low(3) and stack read high(3), each with an increment on its last clock.
- R7: Call runs fetch(4), operand low(3), operand high(4), stack write high(3), stack write low(3), with `sp_dec` on the first clock of each write.
- R8: Conditional call with a false condition runs fetch(4), operand low(3), operand high(3) and stops, with no stack cycles. With a true condition it runs the sequence of R7.
- R9: Restart runs fetch(5), stack write high(3), stack write low(3), with `sp_dec` on the first clock of each write.
- R10: Exchange runs fetch(4), stack read low(3), stack read high(4), stack write high(3), stack write low(5). `sp_inc` pulses on the last clock of the low read and `sp_dec` on the first clock of the low write.
- R11: A start sampled while idle makes the fetch begin on the next clock. `done` is high for exactly the one clock after the final T-state. A start presented during that `done` clock is accepted.
- R12: A start presented while a sequence runs is ignored, including one in the final T-state. The condition flag is captured with the start and has no effect on unconditional classes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-clock request to begin an instruction |
| op_class | input | 3 | Instruction class, sampled with `start` |
| cond_true | input | 1 | Condition result, sampled with `start` |
| cyc_type | output | 3 | Kind of the current machine cycle, 0 when idle |
| cyc_len | output | 3 | Length of the current machine cycle in T-states |
| cyc_start | output | 1 | First T-state of a machine cycle |
| sp_inc | output | 1 | Stack pointer increment strobe |
| sp_dec | output | 1 | Stack pointer decrement strobe |
| done | output | 1 | One-clock pulse after the final T-state |

## Verification
The end of one instruction and the acceptance of the next can share a clock. The `done` pulse and a new start fall together, and the fetch must then begin on the following clock. The bench issues the next start inside the `done` clock and checks that the new sequence follows without a gap or a lost cycle. It also drives a start of a different class in the final T-state of a running sequence. The scoreboard judges this case: an accepted start would add cycles that no expectation covers, and the scoreboard reports those extra cycles as a failure.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;
  localparam int LEN_W = 3;

  typedef enum logic [2:0] {
    CLS_PUSH  = 3'd0,
    CLS_POP   = 3'd1,
    CLS_CALL  = 3'd2,
    CLS_CALLC = 3'd3,
    CLS_RET   = 3'd4,
    CLS_RETC  = 3'd5,
    CLS_RST   = 3'd6,
    CLS_XSP   = 3'd7
  } op_cls_e;

  typedef enum logic [2:0] {
    MC_NONE    = 3'd0,
    MC_FETCH   = 3'd1,
    MC_ARG_LO  = 3'd2,
    MC_ARG_HI  = 3'd3,
    MC_POP_LO  = 3'd4,
    MC_POP_HI  = 3'd5,
    MC_PUSH_HI = 3'd6,
    MC_PUSH_LO = 3'd7
  } mc_kind_e;

  typedef struct packed {
    mc_kind_e         kind;
    logic [LEN_W-1:0] len;
    logic             last;
    logic             pre_dec;
    logic             post_inc;
  } step_t;

  function automatic step_t mk_step(mc_kind_e k, int l, logic lst, logic dec, logic inc);
    step_t s;
    s.kind     = k;
    s.len      = LEN_W'(l);
    s.last     = lst;
    s.pre_dec  = dec;
    s.post_inc = inc;
    return s;
  endfunction
endpackage

// File: rtl/stk_step_rom.sv
module stk_step_rom
  import stk_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  op_cls_e           cls,
  input  logic              cond,
  input  logic [STEP_W-1:0] step,
  output step_t             row
);
  step_t idle_row;
  assign idle_row = mk_step(MC_NONE, 0, 1'b1, 1'b0, 1'b0);

  always_comb begin
    row = idle_row;
    unique case (cls)
      CLS_PUSH, CLS_RST: begin
        case (step)
          STEP_W'(0): row = mk_step(MC_FETCH,   5, 1'b0, 1'b0, 1'b0);
          STEP_W'(1): row = mk_step(MC_PUSH_HI, 3, 1'b0, 1'b1, 1'b0);
          STEP_W'(2): row = mk_step(MC_PUSH_LO, 3, 1'b1, 1'b1, 1'b0);
          default:    row = idle_row;
        endcase
      end
      CLS_POP, CLS_RET, CLS_RETC: begin
        case (step)
          STEP_W'(0): row = (cls == CLS_RETC)
                            ? mk_step(MC_FETCH, 5, !cond, 1'b0, 1'b0)
                            : mk_step(MC_FETCH, 4, 1'b0,  1'b0, 1'b0);
          STEP_W'(1): row = mk_step(MC_POP_LO, 3, 1'b0, 1'b0, 1'b1);
          STEP_W'(2): row = mk_step(MC_POP_HI, 3, 1'b1, 1'b0, 1'b1);
          default:    row = idle_row;
        endcase
      end
      CLS_CALL, CLS_CALLC: begin
        if (cls == CLS_CALL || cond) begin
          case (step)
            STEP_W'(0): row = mk_step(MC_FETCH,   4, 1'b0, 1'b0, 1'b0);
            STEP_W'(1): row = mk_step(MC_ARG_LO,  3, 1'b0, 1'b0, 1'b0);
            STEP_W'(2): row = mk_step(MC_ARG_HI,  4, 1'b0, 1'b0, 1'b0);
            STEP_W'(3): row = mk_step(MC_PUSH_HI, 3, 1'b0, 1'b1, 1'b0);
            STEP_W'(4): row = mk_step(MC_PUSH_LO, 3, 1'b1, 1'b1, 1'b0);
            default:    row = idle_row;
          endcase
        end else begin
          case (step)
            STEP_W'(0): row = mk_step(MC_FETCH,  4, 1'b0, 1'b0, 1'b0);
            STEP_W'(1): row = mk_step(MC_ARG_LO, 3, 1'b0, 1'b0, 1'b0);
            STEP_W'(2): row = mk_step(MC_ARG_HI, 3, 1'b1, 1'b0, 1'b0);
            default:    row = idle_row;
          endcase
        end
      end
      CLS_XSP: begin
        case (step)
          STEP_W'(0): row = mk_step(MC_FETCH,   4, 1'b0, 1'b0, 1'b0);
          STEP_W'(1): row = mk_step(MC_POP_LO,  3, 1'b0, 1'b0, 1'b1);
          STEP_W'(2): row = mk_step(MC_POP_HI,  4, 1'b0, 1'b0, 1'b0);
          STEP_W'(3): row = mk_step(MC_PUSH_HI, 3, 1'b0, 1'b0, 1'b0);
          STEP_W'(4): row = mk_step(MC_PUSH_LO, 5, 1'b1, 1'b1, 1'b0);
          default:    row = idle_row;
        endcase
      end
      default: row = idle_row;
    endcase
  end
endmodule

// File: rtl/stk_tcount.sv
module stk_tcount #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         busy,
  input  logic         cyc_end,
  input  logic         run_end,
  output logic [W-1:0] tcnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)                tcnt <= '0;
    else if (load)             tcnt <= W'(1);
    else if (busy && run_end)  tcnt <= '0;
    else if (busy && cyc_end)  tcnt <= W'(1);
    else if (busy)             tcnt <= tcnt + W'(1);
  end

  // R2: a running sequence always sits on a real T-state
  a_r2_tstate_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tcnt != '0));
endmodule

// File: rtl/stk_sp_strobe.sv
module stk_sp_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic first_t,
  input  logic last_t,
  input  logic pre_dec,
  input  logic post_inc,
  output logic sp_inc,
  output logic sp_dec
);
  assign sp_dec = first_t & pre_dec;
  assign sp_inc = last_t & post_inc;

  // R10: the two pointer strobes never meet in one T-state
  a_r10_inc_dec_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(sp_inc && sp_dec));
endmodule

// File: rtl/stk_seq_top.sv
module stk_seq_top
  import stk_seq_pkg::*;
#(
  parameter int STEP_W = 3,
  parameter int CNT_W  = LEN_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] op_class,
  input  logic       cond_true,
  output logic [2:0] cyc_type,
  output logic [2:0] cyc_len,
  output logic       cyc_start,
  output logic       sp_inc,
  output logic       sp_dec,
  output logic       done
);
  logic              busy;
  op_cls_e           cls_q;
  logic              cond_q;
  logic [STEP_W-1:0] step_q;
  logic              done_q;
  logic [CNT_W-1:0]  tcnt;
  step_t             row;
  logic              accept, first_t, last_t;

  assign accept  = start && !busy;
  assign first_t = busy && (tcnt == CNT_W'(1));
  assign last_t  = busy && (tcnt == CNT_W'(row.len));

  stk_step_rom #(.STEP_W(STEP_W)) u_rom (
    .cls (cls_q),
    .cond(cond_q),
    .step(step_q),
    .row (row)
  );

  stk_tcount #(.W(CNT_W)) u_tcnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .busy   (busy),
    .cyc_end(last_t),
    .run_end(last_t && row.last),
    .tcnt   (tcnt)
  );

  stk_sp_strobe u_sp (
    .clk     (clk),
    .rst_n   (rst_n),
    .first_t (first_t),
    .last_t  (last_t),
    .pre_dec (row.pre_dec),
    .post_inc(row.post_inc),
    .sp_inc  (sp_inc),
    .sp_dec  (sp_dec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cls_q  <= CLS_PUSH;
      cond_q <= 1'b0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        cls_q  <= op_cls_e'(op_class);
        cond_q <= cond_true;
        step_q <= '0;
      end else if (last_t) begin
        if (row.last) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + STEP_W'(1);
        end
      end
    end
  end

  assign cyc_type  = busy ? row.kind : MC_NONE;
  assign cyc_len   = busy ? row.len : '0;
  assign cyc_start = first_t;
  assign done      = done_q;

  // R11: done lasts a single clock
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11: done only follows a clock that showed a machine cycle
  a_r11_done_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(cyc_type) != 3'd0));
  // R12: a start during a run leaves the captured class untouched
  a_r12_class_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(cls_q));
  // R2: the cycle kind holds until the last T-state
  a_r2_kind_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_t) |=> $stable(cyc_type));
  // R2: cyc_start is never seen outside a machine cycle
  a_r2_start_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> (cyc_type != 3'd0));
endmodule

// File: tb/stk_seq_top_tb_top.sv
`timescale 1ns/1ps
module stk_seq_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] op_class = 3'd0;
  logic cond_true = 1'b0;
  logic [2:0] cyc_type, cyc_len;
  logic cyc_start, sp_inc, sp_dec, done;

  always #2.5 clk = ~clk;

  stk_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_class(op_class),
    .cond_true(cond_true), .cyc_type(cyc_type), .cyc_len(cyc_len),
    .cyc_start(cyc_start), .sp_inc(sp_inc), .sp_dec(sp_dec), .done(done)
  );

  int n_run = 0;
  int n_fail = 0;
  int exp_total;
  bit mon_en = 1'b0;

  int q_kind[$];
  int q_len[$];
  int q_inc[$];
  int q_dec[$];
  string q_tag[$];

  task automatic add(input int k, input int l, input int i, input int d, input string tag);
    q_kind.push_back(k); q_len.push_back(l); q_inc.push_back(i);
    q_dec.push_back(d); q_tag.push_back(tag);
    exp_total += l;
  endtask

  task automatic expect_seq(input int cls, input bit cond);
    exp_total = 0;
    case (cls)
      0: begin add(1,5,0,0,"R3");  add(6,3,0,1,"R3");  add(7,3,0,1,"R3");  end
      1: begin add(1,4,0,0,"R4");  add(4,3,1,0,"R4");  add(5,3,1,0,"R4");  end
      2: begin add(1,4,0,0,"R7");  add(2,3,0,0,"R7");  add(3,4,0,0,"R7");
               add(6,3,0,1,"R7");  add(7,3,0,1,"R7");  end
      3: if (cond) begin
           add(1,4,0,0,"R8"); add(2,3,0,0,"R8"); add(3,4,0,0,"R8");
           add(6,3,0,1,"R8"); add(7,3,0,1,"R8");
         end else begin
           add(1,4,0,0,"R8"); add(2,3,0,0,"R8"); add(3,3,0,0,"R8");
         end
      4: begin add(1,4,0,0,"R5");  add(4,3,1,0,"R5");  add(5,3,1,0,"R5");  end
      5: begin add(1,5,0,0,"R6");
               if (cond) begin add(4,3,1,0,"R6"); add(5,3,1,0,"R6"); end
         end
      6: begin add(1,5,0,0,"R9");  add(6,3,0,1,"R9");  add(7,3,0,1,"R9");  end
      default: begin add(1,4,0,0,"R10"); add(4,3,1,0,"R10"); add(5,4,0,0,"R10");
               add(6,3,0,0,"R10"); add(7,5,0,1,"R10"); end
    endcase
    add(-1,0,0,0,"R11");
  endtask

  // Starts at the current negedge; returns at the negedge of fetch T1
  task automatic launch(input int cls, input bit cond);
    expect_seq(cls, cond);
    op_class = 3'(cls); cond_true = cond; start = 1'b1;
    @(negedge clk);
    start = 1'b0; op_class = 3'(cls ^ 1); cond_true = ~cond;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  // R12: injects foreign starts mid-run and in the final T-state
  task automatic run_with_noise(input int cls, input bit cond);
    int total;
    launch(cls, cond);
    total = exp_total;
    for (int t = 1; t < total; t++) begin
      @(negedge clk);
      if (t == 2)          begin start = 1'b1; op_class = 3'(cls ^ 3); end
      else if (t == 3)     start = 1'b0;
      if (t + 1 == total)  begin start = 1'b1; op_class = 3'(cls ^ 5); end
    end
    @(negedge clk);
    start = 1'b0;
    wait_done();
  endtask

  // Monitor / scoreboard
  int cur_len, cur_inc, cur_dec, meas, incs, decs, inc_last;
  string cur_tag;
  bit in_cyc = 1'b0;

  task automatic finalize();
    n_run++;
    if (meas != cur_len || incs != cur_inc || inc_last != cur_inc || decs != cur_dec) begin
      n_fail++;
      $display("FAIL %s (R2) cycle body: len/inc/inc_last/dec act %0d/%0d/%0d/%0d exp %0d/%0d/%0d/%0d",
               cur_tag, meas, incs, inc_last, decs, cur_len, cur_inc, cur_inc, cur_dec);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      if (cyc_start || done) begin
        if (in_cyc) finalize();
        in_cyc = 1'b0;
        n_run++;
        if (q_kind.size() == 0) begin
          n_fail++;
          $display("FAIL R12 unexpected activity: type %0d done %0b, expected none", cyc_type, done);
        end else begin
          int k, l, i, d;
          string tg;
          k = q_kind.pop_front(); l = q_len.pop_front(); i = q_inc.pop_front();
          d = q_dec.pop_front(); tg = q_tag.pop_front();
          if (done) begin
            if (k != -1 || cyc_start) begin
              n_fail++;
              $display("FAIL R11 done: act done=1 start=%0b, exp item type %0d", cyc_start, k);
            end
          end else if (k != int'(cyc_type) || l != int'(cyc_len) || d != int'(sp_dec)) begin
            n_fail++;
            $display("FAIL %s (R2) cycle head: type/len/dec act %0d/%0d/%0b exp %0d/%0d/%0d",
                     tg, cyc_type, cyc_len, sp_dec, k, l, d);
          end
          if (cyc_start && !done) begin
            in_cyc = 1'b1; cur_len = l; cur_inc = i; cur_dec = d; cur_tag = tg;
            meas = 0; incs = 0; decs = 0;
          end
        end
      end
      if (in_cyc) begin
        meas++; incs += int'(sp_inc); decs += int'(sp_dec); inc_last = int'(sp_inc);
      end
    end
  end

  task automatic check_idle(input string tag);
    n_run++;
    if (cyc_type != 0 || cyc_len != 0 || cyc_start || sp_inc || sp_dec || done) begin
      n_fail++;
      $display("FAIL %s idle: type %0d len %0d st %0b inc %0b dec %0b done %0b, exp all 0",
               tag, cyc_type, cyc_len, cyc_start, sp_inc, sp_dec, done);
    end
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired, exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");               // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");               // R1 after reset
    mon_en = 1'b1;
    // every class, with both condition values
    for (int c = 0; c < 8; c++) begin
      for (int cv = 0; cv < 2; cv++) begin
        launch(c, cv[0]);
        wait_done();
        @(negedge clk);
        @(negedge clk);
      end
    end
    // R11: back-to-back, start inside the done clock
    launch(2, 1'b1);
    wait_done();
    launch(7, 1'b0);
    wait_done();
    launch(5, 1'b1);
    wait_done();
    launch(3, 1'b0);
    wait_done();
    @(negedge clk);
    check_idle("R11");
    // R12: foreign starts during runs
    run_with_noise(0, 1'b0);
    @(negedge clk);
    run_with_noise(7, 1'b1);
    @(negedge clk);
    run_with_noise(5, 1'b0);
    @(negedge clk);
    check_idle("R12");
    // R1: reset in the middle of a sequence
    mon_en = 1'b0;
    op_class = 3'd2; cond_true = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    q_kind.delete(); q_len.delete(); q_inc.delete(); q_dec.delete(); q_tag.delete();
    in_cyc = 1'b0;
    @(negedge clk);
    check_idle("R1");
    mon_en = 1'b1;
    launch(1, 1'b0);
    wait_done();
    repeat (2) @(negedge clk);
    n_run++;
    if (q_kind.size() != 0) begin
      n_fail++;
      $display("FAIL R11 leftover expectations: act %0d exp 0", q_kind.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule